// File: doc/BRIEF.md
# DS3 C-bit Receive Overhead Extractor

This block sits behind a DS3 receive framer. It takes the received line bit stream one bit per enabled clock, along with a marker that the framer raises on the first bit of each C-bit parity multiframe. From that marker it tracks the bit position within the 4760-bit multiframe. The multiframe has 7 subframes, each made of 8 blocks. Each block is one overhead bit followed by 84 payload bits.

Every overhead bit (the X, P, M, F and C bits) is sent out on a serial overhead port. The port has a strobe that is high once per overhead bit and a start marker that is high with the first X bit. The block keeps even parity over the payload of each multiframe. In the next multiframe it replaces the two line parity bits and the three path parity bits with an error flag: the received bit XOR the parity it computed. The block also copies the far-end alarm channel bit and the three path maintenance data-link bits to their own side outputs, for controllers further downstream.

Every output is registered. Each result appears one clock after the enabled input bit that produced it.

Top module: `ds3_cbit_oh_extract`

## Requirements
- R1: No strobe or marker is produced until the first enabled bit with `rx_mfstart` high. That bit is taken as position 0 of a multiframe, which is the X1 overhead bit.
- R2: Within a multiframe, the bit at offset 0 of each 85-bit block is an overhead bit. For each such bit, `oh_stb` is high for exactly one cycle, one clock after the bit is accepted. That gives 56 strobes per multiframe and no strobe for payload bits.
- R3: `oh_sof` is high only together with the strobe of overhead bit 0 of subframe 0, which is X1.
- R4: The overhead order in each subframe is: lead bit (X, X, P, P, M, M, M for subframes 0 to 6), F, C, F, C, F, C, F. Every overhead bit that is not a parity slot appears on `oh_data` unchanged.
- R5: There are five parity slots: P1 (subframe 2, block 0), P2 (subframe 3, block 0) and C31/C32/C33 (subframe 2, blocks 2, 4, 6). In each of them, `oh_data` is the received bit XOR the even parity of all payload bits of the previous complete multiframe, so 1 means an error.
- R6: Until one complete multiframe has been accumulated after lock or after realignment, every parity slot outputs 0 on `oh_data`.
- R7: The alarm channel bit C13 (subframe 0, block 6) also appears on `feac_data`, with `feac_stb` high in the same cycle as its overhead strobe.
- R8: The data-link bits C51/C52/C53 (subframe 4, blocks 2, 4, 6) also appear on `dl_data`, with `dl_stb` high in the same cycle as their overhead strobe.
- R9: A cycle with `rx_en` low is ignored. The position does not advance, and the next cycle has no strobe.
- R10: If `rx_mfstart` arrives on an enabled bit at any position other than 0, the block realigns. That bit becomes X1 and carries `oh_sof`, and the partial parity is discarded, as described in R6.
- R11: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Received bit valid this cycle |
| rx_data | input | 1 | Received DS3 bit |
| rx_mfstart | input | 1 | Framer marker: this bit is the first of a multiframe |
| oh_data | output | 1 | Serial overhead bit, with the parity slots replaced by error flags |
| oh_stb | output | 1 | Overhead bit strobe |
| oh_sof | output | 1 | High with the X1 overhead bit |
| feac_data | output | 1 | Alarm channel bit C13 |
| feac_stb | output | 1 | Strobe for `feac_data` |
| dl_data | output | 1 | Data-link bit C51/C52/C53 |
| dl_stb | output | 1 | Strobe for `dl_data` |

## Verification
A position counter that drifts by even one bit shifts every strobe away from a block boundary. It also makes the per-frame strobe count go wrong, and both show up at the ports within one 85-bit block. A wrong parity accumulator stays hidden until the next multiframe's P and C3 slots, so the bench sends frames whose parity bits are correct and frames with chosen errors injected, and checks the flag pattern in each. A realign or stall that is handled badly shows as `oh_sof` on the wrong bit, or as a frame whose strobe count is not 56.

// File: rtl/ds3oh_pkg.sv
package ds3oh_pkg;

  // Multiframe geometry
  localparam int SF_COUNT  = 7;
  localparam int BLK_COUNT = 8;
  localparam int BLK_LEN   = 85;
  localparam int SF_W      = $clog2(SF_COUNT);
  localparam int BLK_W     = $clog2(BLK_COUNT);
  localparam int BI_W      = $clog2(BLK_LEN);

  typedef logic [SF_W-1:0]  sf_t;
  typedef logic [BLK_W-1:0] blk_t;

  // Parity slots: P1/C31..C33 in subframe 2 (even blocks), P2 in subframe 3 block 0
  function automatic logic is_par_slot(sf_t sf, blk_t blk);
    return (sf == sf_t'(2) && !blk[0]) || (sf == sf_t'(3) && blk == '0);
  endfunction

  // C13: subframe 0, third C bit
  function automatic logic is_feac_slot(sf_t sf, blk_t blk);
    return sf == '0 && blk == blk_t'(6);
  endfunction

  // C51..C53: subframe 4, C-bit blocks
  function automatic logic is_dl_slot(sf_t sf, blk_t blk);
    return sf == sf_t'(4) && blk != '0 && !blk[0];
  endfunction

  // Running even parity
  function automatic logic parity_fold(logic acc, logic take, logic d);
    return acc ^ (take & d);
  endfunction

  // Overhead output value: parity slots become an error flag
  function automatic logic oh_value(logic par_slot, logic ready, logic rx, logic calc);
    return par_slot ? (ready & (rx ^ calc)) : rx;
  endfunction

endpackage

// File: rtl/ds3oh_position.sv
module ds3oh_position #(
  parameter int SF_N  = ds3oh_pkg::SF_COUNT,
  parameter int BLK_N = ds3oh_pkg::BLK_COUNT,
  parameter int LEN   = ds3oh_pkg::BLK_LEN
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bit_en,
  input  logic                      mf_mark,
  output logic                      cur_valid,
  output logic                      cur_oh,
  output logic [$clog2(SF_N)-1:0]   cur_sf,
  output logic [$clog2(BLK_N)-1:0]  cur_blk,
  output logic                      frame_last,
  output logic                      realign
);
  localparam int SW = $clog2(SF_N);
  localparam int BW = $clog2(BLK_N);
  localparam int IW = $clog2(LEN);
  localparam logic [SW-1:0] SF_LAST  = SW'(SF_N - 1);
  localparam logic [BW-1:0] BLK_LAST = BW'(BLK_N - 1);
  localparam logic [IW-1:0] BI_LAST  = IW'(LEN - 1);

  logic [SW-1:0] sf_q;
  logic [BW-1:0] blk_q;
  logic [IW-1:0] bi_q, cur_bi;
  logic          locked_q, at_zero;

  assign at_zero    = (sf_q == '0) && (blk_q == '0) && (bi_q == '0);
  assign cur_sf     = mf_mark ? '0 : sf_q;
  assign cur_blk    = mf_mark ? '0 : blk_q;
  assign cur_bi     = mf_mark ? '0 : bi_q;
  assign cur_valid  = bit_en && (mf_mark || locked_q);
  assign cur_oh     = (cur_bi == '0);
  assign realign    = bit_en && mf_mark && locked_q && !at_zero;
  assign frame_last = (cur_sf == SF_LAST) && (cur_blk == BLK_LAST) && (cur_bi == BI_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sf_q     <= '0;
      blk_q    <= '0;
      bi_q     <= '0;
      locked_q <= 1'b0;
    end else if (cur_valid) begin
      locked_q <= 1'b1;
      if (cur_bi != BI_LAST) begin
        sf_q  <= cur_sf;
        blk_q <= cur_blk;
        bi_q  <= cur_bi + 1'b1;
      end else begin
        bi_q <= '0;
        if (cur_blk != BLK_LAST) begin
          sf_q  <= cur_sf;
          blk_q <= cur_blk + 1'b1;
        end else begin
          blk_q <= '0;
          sf_q  <= (cur_sf == SF_LAST) ? '0 : cur_sf + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ds3oh_parity.sv
module ds3oh_parity (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic is_payload,
  input  logic data,
  input  logic frame_last,
  input  logic restart,
  output logic par_prev,
  output logic par_ready
);
  import ds3oh_pkg::*;

  logic acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= 1'b0;
      par_prev  <= 1'b0;
      par_ready <= 1'b0;
    end else if (restart) begin
      acc_q     <= 1'b0;
      par_ready <= 1'b0;
    end else if (bit_valid) begin
      if (frame_last) begin
        par_prev  <= parity_fold(acc_q, is_payload, data);
        par_ready <= 1'b1;
        acc_q     <= 1'b0;
      end else begin
        acc_q <= parity_fold(acc_q, is_payload, data);
      end
    end
  end
endmodule

// File: rtl/ds3_cbit_oh_extract.sv
module ds3_cbit_oh_extract #(
  parameter int SUBFRAMES = ds3oh_pkg::SF_COUNT,
  parameter int BLOCKS    = ds3oh_pkg::BLK_COUNT,
  parameter int BLOCK_LEN = ds3oh_pkg::BLK_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic rx_data,
  input  logic rx_mfstart,
  output logic oh_data,
  output logic oh_stb,
  output logic oh_sof,
  output logic feac_data,
  output logic feac_stb,
  output logic dl_data,
  output logic dl_stb
);
  import ds3oh_pkg::*;

  localparam int SW = $clog2(SUBFRAMES);
  localparam int BW = $clog2(BLOCKS);

  // Named internal events
  logic          cur_valid, cur_oh, frame_last, realign;
  logic [SW-1:0] cur_sf;
  logic [BW-1:0] cur_blk;
  logic          take_oh, par_slot, feac_slot, dl_slot;
  logic          par_prev, par_ready;

  ds3oh_position #(.SF_N(SUBFRAMES), .BLK_N(BLOCKS), .LEN(BLOCK_LEN)) u_pos (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (rx_en),
    .mf_mark    (rx_mfstart),
    .cur_valid  (cur_valid),
    .cur_oh     (cur_oh),
    .cur_sf     (cur_sf),
    .cur_blk    (cur_blk),
    .frame_last (frame_last),
    .realign    (realign)
  );

  ds3oh_parity u_par (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (cur_valid),
    .is_payload (!cur_oh),
    .data       (rx_data),
    .frame_last (frame_last),
    .restart    (realign),
    .par_prev   (par_prev),
    .par_ready  (par_ready)
  );

  assign take_oh   = cur_valid && cur_oh;
  assign par_slot  = take_oh && is_par_slot(cur_sf, cur_blk);
  assign feac_slot = take_oh && is_feac_slot(cur_sf, cur_blk);
  assign dl_slot   = take_oh && is_dl_slot(cur_sf, cur_blk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oh_data   <= 1'b0;
      oh_stb    <= 1'b0;
      oh_sof    <= 1'b0;
      feac_data <= 1'b0;
      feac_stb  <= 1'b0;
      dl_data   <= 1'b0;
      dl_stb    <= 1'b0;
    end else begin
      oh_stb    <= take_oh;
      oh_sof    <= take_oh && cur_sf == '0 && cur_blk == '0;
      oh_data   <= take_oh && oh_value(par_slot, par_ready, rx_data, par_prev);
      feac_stb  <= feac_slot;
      feac_data <= feac_slot && rx_data;
      dl_stb    <= dl_slot;
      dl_data   <= dl_slot && rx_data;
    end
  end
endmodule

// File: rtl/ds3oh_checker.sv
module ds3oh_checker (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic oh_stb,
  input logic oh_sof,
  input logic feac_stb,
  input logic dl_stb,
  input logic realign,
  input logic par_ready
);
  logic [5:0] since_sof;
  logic       seen_sof;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_sof <= '0;
      seen_sof  <= 1'b0;
    end else if (oh_sof) begin
      since_sof <= '0;
      seen_sof  <= 1'b1;
    end else if (oh_stb) begin
      since_sof <= since_sof + 1'b1;
    end
  end

  p_no_stb_before_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_sof && oh_stb) |-> oh_sof);
  p_oh_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (oh_stb && !oh_sof) |-> (since_sof < 6'd55));
  p_sof_has_stb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    oh_sof |-> oh_stb);
  p_feac_in_oh_r7: assert property (@(posedge clk) disable iff (!rst_n)
    feac_stb |-> (oh_stb && !dl_stb && !oh_sof));
  p_dl_in_oh_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dl_stb |-> (oh_stb && !oh_sof));
  p_stall_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !oh_stb);
  p_realign_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> !par_ready);
endmodule

bind ds3_cbit_oh_extract ds3oh_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en     (rx_en),
  .oh_stb    (oh_stb),
  .oh_sof    (oh_sof),
  .feac_stb  (feac_stb),
  .dl_stb    (dl_stb),
  .realign   (realign),
  .par_ready (par_ready)
);

// File: tb/ds3_cbit_oh_extract_test.sv
`timescale 1ns/1ps
module ds3_cbit_oh_extract_test;
  localparam int FRAME = 4760;
  localparam int BLK   = 85;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, rx_data = 1'b0, rx_mfstart = 1'b0;
  logic oh_data, oh_stb, oh_sof, feac_data, feac_stb, dl_data, dl_stb;

  always #4 clk = ~clk;

  ds3_cbit_oh_extract uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_data(rx_data), .rx_mfstart(rx_mfstart),
    .oh_data(oh_data), .oh_stb(oh_stb), .oh_sof(oh_sof),
    .feac_data(feac_data), .feac_stb(feac_stb), .dl_data(dl_data), .dl_stb(dl_stb)
  );

  int n_checks = 0, n_errors = 0;
  bit done = 0;

  // Bench model of the frame position and parity
  bit m_locked = 0, m_acc = 0, m_prev = 0, m_ok = 0;
  int m_pos = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit last_par;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic step(input bit b, input bit mf, input bit en);
    bit v, oh, pslot, fslot, dslot, eb;
    int idx, sf, blk;
    v = en && (mf || m_locked);
    if (v && mf && m_locked && m_pos != 0) begin m_acc = 0; m_ok = 0; end
    if (v && mf) begin m_pos = 0; m_locked = 1; end
    oh  = v && (m_pos % BLK == 0);
    idx = m_pos / BLK; sf = idx / 8; blk = idx % 8;
    pslot = oh && ((sf == 2 && blk % 2 == 0) || (sf == 3 && blk == 0));
    fslot = oh && sf == 0 && blk == 6;
    dslot = oh && sf == 4 && (blk == 2 || blk == 4 || blk == 6);
    eb = !oh ? 1'b0 : (pslot ? (m_ok ? (b ^ m_prev) : 1'b0) : b);
    @(negedge clk);
    rx_data = b; rx_mfstart = mf; rx_en = en;
    @(posedge clk); #1;
    check(oh_stb == oh, en ? "R2 strobe" : "R9 stall strobe", oh_stb, oh);
    check(oh_sof == (oh && idx == 0), "R3 sof", oh_sof, oh && idx == 0);
    if (oh) check(oh_data == eb, pslot ? (m_ok ? "R5 parity flag" : "R6 parity held") : "R4 raw overhead", oh_data, eb);
    check(feac_stb == fslot, "R7 feac strobe", feac_stb, fslot);
    if (fslot) check(feac_data == b, "R7 feac data", feac_data, b);
    check(dl_stb == dslot, "R8 dl strobe", dl_stb, dslot);
    if (dslot) check(dl_data == b, "R8 dl data", dl_data, b);
    last_par = pslot;
    if (v) begin
      if (!oh) m_acc ^= b;
      if (m_pos == FRAME - 1) begin m_prev = m_acc; m_acc = 0; m_ok = 1; m_pos = 0; end
      else m_pos++;
    end
  endtask

  function automatic bit bit_for(int i, int inj);
    int idx, sf, blk, k;
    if (i % BLK != 0) return rnd();
    idx = i / BLK; sf = idx / 8; blk = idx % 8;
    if ((sf == 2 && blk % 2 == 0) || (sf == 3 && blk == 0)) begin
      k = (sf == 3) ? 1 : (blk == 0 ? 0 : 1 + blk / 2);
      return m_prev ^ inj[k];
    end
    return rnd();
  endfunction

  task automatic send_frame(input bit mark, input int inj, input int stall_every, input bit flags_on, input int nbits);
    int stb_n = 0, err_n = 0, want;
    for (int i = 0; i < nbits; i++) begin
      if (stall_every > 0 && i % stall_every == 3) step(rnd(), 1'b0, 1'b0);
      step(bit_for(i, inj), mark && i == 0, 1'b1);
      if (i == 0 && mark) check(oh_sof == 1'b1, "R10/R1 sof on marked bit", oh_sof, 1);
      if (oh_stb) stb_n++;
      if (oh_stb && last_par && oh_data) err_n++;
    end
    if (nbits == FRAME) begin
      check(stb_n == 56, stall_every > 0 ? "R9 strobes per stalled frame" : "R2 strobes per frame", stb_n, 56);
      want = flags_on ? $countones(inj[4:0]) : 0;
      check(err_n == want, flags_on ? "R5 flagged errors" : "R6 no flags before full frame", err_n, want);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    check({oh_data, oh_stb, oh_sof, feac_data, feac_stb, dl_data, dl_stb} == 7'b0, "R11 reset outputs", 
          {oh_data, oh_stb, oh_sof, feac_data, feac_stb, dl_data, dl_stb}, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_prelock();
    int seen = 0;
    for (int i = 0; i < 300; i++) begin
      step(rnd(), 1'b0, 1'b1);
      if (oh_stb || oh_sof) seen++;
    end
    check(seen == 0, "R1 no strobe before lock", seen, 0);
  endtask

  task automatic t_aligned();
    send_frame(1'b1, 5'b10101, 0, 1'b0, FRAME);  // first frame after lock
    send_frame(1'b1, 5'b00000, 0, 1'b1, FRAME);  // clean parity
    send_frame(1'b0, 5'b01010, 0, 1'b1, FRAME);  // P2 and C32 wrong, no marker needed
  endtask

  task automatic t_stall();
    send_frame(1'b1, 5'b11001, 7, 1'b1, FRAME);
  endtask

  task automatic t_realign();
    send_frame(1'b1, 5'b00000, 0, 1'b1, 1234);   // cut short
    send_frame(1'b1, 5'b11111, 0, 1'b0, FRAME);  // R10: partial parity discarded
    send_frame(1'b1, 5'b00101, 0, 1'b1, FRAME);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_prelock();
    t_aligned();
    t_stall();
    t_realign();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule